// File: doc/BRIEF.md
# Triggered Event Acquisition Sequencer

This block runs one detector event at a time. An acquisition command blocks the trigger, zeroes the event counter and parks the sequencer until a reset arrives. After the reset it arms for one trigger and counts that trigger. It then blocks every later trigger until the event has been read out and the next reset has been seen. Two front-end channels are captured into two external buffers through registered write ports. Each channel starts on its own data-valid response and takes a fixed number of 10-bit samples. When both channels have finished, the sequencer fetches a timing byte and then a two-byte temperature word over a shared byte input, and it raises the ready flag.

Only one event is held at a time. The ready flag stays up until the selected reset source fires. That source is either an external reset pulse or, in automatic mode, a readout-done pulse. A status byte reports readiness, per-channel completion and whether an event is in progress. A per-channel error flag marks a channel whose data-valid response never came, so that readout can skip that event.

The sequencer has these states. IDLE waits after power-up. DISARM follows the command. WAIT_RST waits for the first reset. WAIT_TRIG is the armed state. CAPTURE lasts until both channels end. RD_TIME, RD_TEMP_LO and RD_TEMP_HI take one cycle each. READY holds the finished event. The transitions are:

- The command moves any state to DISARM.
- DISARM always moves to WAIT_RST.
- WAIT_RST moves to WAIT_TRIG on the selected reset.
- WAIT_TRIG moves to CAPTURE on a trigger.
- CAPTURE moves to RD_TIME when both channels have ended.
- RD_TIME moves to RD_TEMP_LO, then to RD_TEMP_HI, then to READY.
- READY moves to WAIT_TRIG on the selected reset.

Each channel unit has four states:

- C_IDLE holds after power-up or after an abort.
- C_WAIT_DV waits for data-valid, with a timeout.
- C_RUN writes samples.
- C_END holds the finished result.

A trigger moves C_IDLE or C_END to C_WAIT_DV. Data-valid moves C_WAIT_DV to C_RUN, and a timeout moves it to C_END. The last sample moves C_RUN to C_END. The acquisition command moves every channel state to C_IDLE.

Top module: `evt_acq_top`

## Requirements
- R1: In reset the block shows status 0, counter 0, trigger disabled and no buffer writes. A `start_acq` pulse in any state clears the counter, the channel flags and any capture in progress. It disables the trigger until a selected reset is seen.
- R2: With `auto_rst_en`=0 only `ext_rst` acts as the reset. With `auto_rst_en`=1 only a one-cycle `rd_done` pulse acts as the reset. The other input has no effect.
- R3: A trigger is accepted only while `trig_en`=1 (the WAIT_TRIG state). Each accepted trigger adds 1 to `evt_cnt`. At all other times triggers are ignored and `evt_cnt` holds.
- R4: Each channel begins at the first cycle after the trigger in which its own `dv_in` bit is 1. The sample present in that cycle is written to address 0, and the samples of the following cycles go to addresses 1, 2 and so on. Each write appears on the port one cycle after its sample.
- R5: Each captured channel produces exactly 160 writes per event, at addresses 0 to 159.
- R6: The trigger edge starts a per-channel timer at 0, which advances 1 per cycle. If `dv_in` is still 0 when the timer reaches 1023, the channel's `ch_err` bit is set and it writes nothing, but the event still completes.
- R7: After both channels end, `aux_sel` selects the timing byte (0), then the low temperature byte (1), then the high temperature byte (2). Each selection lasts one cycle. These bytes are latched into `time_word` and `temp_word`, and then the event becomes ready.
- R8: The status byte is laid out as follows. Bit 7 is set when the event is ready. Bit 5 is set when channel 1 completed 160 samples, and bit 4 when channel 0 did. Bit 0 is set from capture through the last auxiliary read. All other bits are 0.
- R9: Ready holds, with the trigger vetoed, until the selected reset arrives. The reset returns the block to the armed state with no buffer write pending.
- R10: The per-channel completion and error flags clear on each accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_acq | input | 1 | Acquisition command pulse |
| auto_rst_en | input | 1 | Selects the reset source: 0 external, 1 readout-done |
| ext_rst | input | 1 | External reset pulse |
| rd_done | input | 1 | Readout-done pulse |
| trig_in | input | 1 | Trigger |
| dv_in | input | 2 | Per-channel data-valid response |
| smp0_in | input | 10 | Channel 0 sample |
| smp1_in | input | 10 | Channel 1 sample |
| aux_byte | input | 8 | Byte selected by aux_sel |
| trig_en | output | 1 | Trigger armed |
| aux_sel | output | 2 | Auxiliary byte select: 0 timing, 1 temperature low, 2 temperature high, 3 none |
| buf0_we | output | 1 | Buffer 0 write enable |
| buf0_addr | output | 8 | Buffer 0 address |
| buf0_data | output | 10 | Buffer 0 data |
| buf1_we | output | 1 | Buffer 1 write enable |
| buf1_addr | output | 8 | Buffer 1 address |
| buf1_data | output | 10 | Buffer 1 data |
| status | output | 8 | Status byte |
| ch_err | output | 2 | Per-channel data-valid timeout flag |
| evt_cnt | output | 16 | Event counter |
| time_word | output | 8 | Latched timing byte |
| temp_word | output | 16 | Latched temperature word |

## Verification
The properties assume several things about the inputs. `start_acq` is a short pulse. The source `aux_byte` follows `aux_sel` within the same cycle. `dv_in` stays low until after the trigger that starts a capture. The stimulus holds both data-valid bits at 0 outside capture windows and raises each one only after the trigger edge. It also drives `aux_byte` as a combinational function of `aux_sel`. Reset pulses are one cycle wide and are issued only in the waiting states or the ready state.

// File: rtl/evt_acq_pkg.sv
package evt_acq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DISARM,
        S_WAIT_RST,
        S_WAIT_TRIG,
        S_CAPTURE,
        S_RD_TIME,
        S_RD_TEMP_LO,
        S_RD_TEMP_HI,
        S_READY
    } seq_state_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_WAIT_DV,
        C_RUN,
        C_END
    } cap_state_t;

    localparam logic [1:0] AUX_TIME = 2'd0;
    localparam logic [1:0] AUX_TLO  = 2'd1;
    localparam logic [1:0] AUX_THI  = 2'd2;
    localparam logic [1:0] AUX_NONE = 2'd3;

endpackage

// File: rtl/evt_chan_capture.sv
module evt_chan_capture
    import evt_acq_pkg::*;
#(
    parameter int DW    = 10,
    parameter int NSMP  = 160,
    parameter int DEPTH = 256,
    parameter int TMO   = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     abort,
    input  logic                     start,
    input  logic                     dv,
    input  logic [DW-1:0]            smp,
    output logic                     buf_we,
    output logic [$clog2(DEPTH)-1:0] buf_addr,
    output logic [DW-1:0]            buf_data,
    output logic                     done,
    output logic                     err,
    output logic                     fin
);
    localparam int AW = $clog2(DEPTH);
    localparam int TW = $clog2(TMO);
    localparam logic [AW-1:0] LAST = AW'(NSMP - 1);
    localparam logic [TW-1:0] TLIM = TW'(TMO - 1);

    cap_state_t    st_q, st_d;
    logic [AW-1:0] cnt_q;
    logic [TW-1:0] tmr_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_IDLE, C_END: if (start) st_d = C_WAIT_DV;
            C_WAIT_DV:     if (dv) st_d = C_RUN;
                           else if (tmr_q == TLIM) st_d = C_END;
            C_RUN:         if (cnt_q == LAST) st_d = C_END;
            default:       st_d = C_IDLE;
        endcase
        if (abort) st_d = C_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= C_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we   <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
            cnt_q    <= '0;
            tmr_q    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            buf_we <= 1'b0;
            if (abort) begin
                done <= 1'b0;
                err  <= 1'b0;
            end else begin
                unique case (st_q)
                    C_IDLE, C_END: if (start) begin
                        done  <= 1'b0;
                        err   <= 1'b0;
                        tmr_q <= '0;
                    end
                    C_WAIT_DV: if (dv) begin
                        buf_we   <= 1'b1;
                        buf_addr <= '0;
                        buf_data <= smp;
                        cnt_q    <= AW'(1);
                    end else if (tmr_q == TLIM) begin
                        err <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                    C_RUN: begin
                        buf_we   <= 1'b1;
                        buf_addr <= cnt_q;
                        buf_data <= smp;
                        cnt_q    <= cnt_q + 1'b1;
                        if (cnt_q == LAST) done <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign fin = (st_q == C_END);

endmodule

// File: rtl/evt_seq_fsm.sv
module evt_seq_fsm
    import evt_acq_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_acq,
    input  logic           auto_rst_en,
    input  logic           ext_rst,
    input  logic           rd_done,
    input  logic           trig_in,
    input  logic [NCH-1:0] ch_fin,
    input  logic [7:0]     aux_byte,
    output logic           trig_en,
    output logic           cap_start,
    output logic [1:0]     aux_sel,
    output logic           busy,
    output logic           ready,
    output logic [CW-1:0]  evt_cnt,
    output logic [7:0]     time_word,
    output logic [15:0]    temp_word
);
    seq_state_t st_q, st_d;
    logic       eff_rst;

    assign eff_rst = auto_rst_en ? rd_done : ext_rst;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:       st_d = S_IDLE;
            S_DISARM:     st_d = S_WAIT_RST;
            S_WAIT_RST:   if (eff_rst) st_d = S_WAIT_TRIG;
            S_WAIT_TRIG:  if (trig_in) st_d = S_CAPTURE;
            S_CAPTURE:    if (&ch_fin) st_d = S_RD_TIME;
            S_RD_TIME:    st_d = S_RD_TEMP_LO;
            S_RD_TEMP_LO: st_d = S_RD_TEMP_HI;
            S_RD_TEMP_HI: st_d = S_READY;
            S_READY:      if (eff_rst) st_d = S_WAIT_TRIG;
            default:      st_d = S_IDLE;
        endcase
        if (start_acq) st_d = S_DISARM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        trig_en   = (st_q == S_WAIT_TRIG);
        cap_start = trig_en && trig_in && !start_acq;
        ready     = (st_q == S_READY);
        busy      = 1'b0;
        aux_sel   = AUX_NONE;
        unique case (st_q)
            S_CAPTURE:    busy = 1'b1;
            S_RD_TIME:    begin busy = 1'b1; aux_sel = AUX_TIME; end
            S_RD_TEMP_LO: begin busy = 1'b1; aux_sel = AUX_TLO;  end
            S_RD_TEMP_HI: begin busy = 1'b1; aux_sel = AUX_THI;  end
            default:      ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_cnt   <= '0;
            time_word <= '0;
            temp_word <= '0;
        end else begin
            if (start_acq)      evt_cnt <= '0;
            else if (cap_start) evt_cnt <= evt_cnt + 1'b1;
            if (st_q == S_RD_TIME)    time_word       <= aux_byte;
            if (st_q == S_RD_TEMP_LO) temp_word[7:0]  <= aux_byte;
            if (st_q == S_RD_TEMP_HI) temp_word[15:8] <= aux_byte;
        end
    end

endmodule

// File: rtl/evt_acq_top.sv
module evt_acq_top
    import evt_acq_pkg::*;
#(
    parameter int DW    = 10,
    parameter int NSMP  = 160,
    parameter int DEPTH = 256,
    parameter int TMO   = 1024,
    parameter int CW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_acq,
    input  logic                     auto_rst_en,
    input  logic                     ext_rst,
    input  logic                     rd_done,
    input  logic                     trig_in,
    input  logic [1:0]               dv_in,
    input  logic [DW-1:0]            smp0_in,
    input  logic [DW-1:0]            smp1_in,
    input  logic [7:0]               aux_byte,
    output logic                     trig_en,
    output logic [1:0]               aux_sel,
    output logic                     buf0_we,
    output logic [$clog2(DEPTH)-1:0] buf0_addr,
    output logic [DW-1:0]            buf0_data,
    output logic                     buf1_we,
    output logic [$clog2(DEPTH)-1:0] buf1_addr,
    output logic [DW-1:0]            buf1_data,
    output logic [7:0]               status,
    output logic [1:0]               ch_err,
    output logic [CW-1:0]            evt_cnt,
    output logic [7:0]               time_word,
    output logic [15:0]              temp_word
);
    localparam int AW  = $clog2(DEPTH);
    localparam int NCH = 2;

    logic          cap_start, busy, ready;
    logic [DW-1:0] smp_a  [NCH];
    logic          we_a   [NCH];
    logic [AW-1:0] addr_a [NCH];
    logic [DW-1:0] data_a [NCH];
    logic [NCH-1:0] done_v, err_v, fin_v;

    assign smp_a[0] = smp0_in;
    assign smp_a[1] = smp1_in;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        evt_chan_capture #(
            .DW(DW), .NSMP(NSMP), .DEPTH(DEPTH), .TMO(TMO)
        ) i_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .abort    (start_acq),
            .start    (cap_start),
            .dv       (dv_in[g]),
            .smp      (smp_a[g]),
            .buf_we   (we_a[g]),
            .buf_addr (addr_a[g]),
            .buf_data (data_a[g]),
            .done     (done_v[g]),
            .err      (err_v[g]),
            .fin      (fin_v[g])
        );
    end

    evt_seq_fsm #(.CW(CW), .NCH(NCH)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_acq   (start_acq),
        .auto_rst_en (auto_rst_en),
        .ext_rst     (ext_rst),
        .rd_done     (rd_done),
        .trig_in     (trig_in),
        .ch_fin      (fin_v),
        .aux_byte    (aux_byte),
        .trig_en     (trig_en),
        .cap_start   (cap_start),
        .aux_sel     (aux_sel),
        .busy        (busy),
        .ready       (ready),
        .evt_cnt     (evt_cnt),
        .time_word   (time_word),
        .temp_word   (temp_word)
    );

    assign buf0_we   = we_a[0];
    assign buf0_addr = addr_a[0];
    assign buf0_data = data_a[0];
    assign buf1_we   = we_a[1];
    assign buf1_addr = addr_a[1];
    assign buf1_data = data_a[1];
    assign ch_err    = err_v;
    assign status    = {ready, 1'b0, done_v[1], done_v[0], 3'b000, busy};

endmodule

// File: rtl/evt_acq_chk.sv
module evt_acq_chk #(
    parameter int AW   = 8,
    parameter int NSMP = 160,
    parameter int CW   = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_acq,
    input logic          trig_in,
    input logic          trig_en,
    input logic [1:0]    aux_sel,
    input logic          buf0_we,
    input logic [AW-1:0] buf0_addr,
    input logic          buf1_we,
    input logic [AW-1:0] buf1_addr,
    input logic          st_ready,
    input logic          st_done1,
    input logic          st_done0,
    input logic          st_busy,
    input logic [1:0]    ch_err,
    input logic [CW-1:0] evt_cnt
);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !start_acq) |=> $stable(evt_cnt)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && trig_in && !start_acq) |=> (evt_cnt == CW'($past(evt_cnt) + 1'b1))); // R3
    AST_WE0_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (buf0_we && buf0_addr != '0) |-> ($past(buf0_we) && buf0_addr == AW'($past(buf0_addr) + 1'b1))); // R4
    AST_WE1_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (buf1_we && buf1_addr != '0) |-> ($past(buf1_we) && buf1_addr == AW'($past(buf1_addr) + 1'b1))); // R4
    AST_ADDR0_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        buf0_we |-> (buf0_addr < AW'(NSMP))); // R5
    AST_ADDR1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        buf1_we |-> (buf1_addr < AW'(NSMP))); // R5
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_err[0] && st_done0) && !(ch_err[1] && st_done1)); // R6
    AST_READY_AFTER_AUX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ready) |-> ($past(aux_sel) == 2'd2)); // R7
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_ready && st_busy)); // R8
    AST_ARMED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_en |-> !(buf0_we || buf1_we)); // R9
endmodule

bind evt_acq_top evt_acq_chk #(.AW(AW), .NSMP(NSMP), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acq (start_acq),
    .trig_in   (trig_in),
    .trig_en   (trig_en),
    .aux_sel   (aux_sel),
    .buf0_we   (buf0_we),
    .buf0_addr (buf0_addr),
    .buf1_we   (buf1_we),
    .buf1_addr (buf1_addr),
    .st_ready  (status[7]),
    .st_done1  (status[5]),
    .st_done0  (status[4]),
    .st_busy   (status[0]),
    .ch_err    (ch_err),
    .evt_cnt   (evt_cnt)
);

// File: tb/test_evt_acq_top.sv
`timescale 1ns/100ps
module test_evt_acq_top;

    typedef struct packed {
        logic [11:0] d0;
        logic [11:0] d1;
        logic [3:0]  st0;
        logic [3:0]  st1;
        logic [7:0]  tdc;
        logic [15:0] temp;
        logic        autom;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{d0:12'd3,    d1:12'd3,    st0:4'd1, st1:4'd1, tdc:8'h5A, temp:16'h1234, autom:1'b0},
        '{d0:12'd0,    d1:12'd20,   st0:4'd3, st1:4'd5, tdc:8'hA5, temp:16'hBEEF, autom:1'b1},
        '{d0:12'd50,   d1:12'd1,    st0:4'd7, st1:4'd2, tdc:8'h01, temp:16'h8001, autom:1'b0},
        '{d0:12'd1023, d1:12'd5,    st0:4'd1, st1:4'd9, tdc:8'hFF, temp:16'h00FF, autom:1'b1},
        '{d0:12'd7,    d1:12'd2000, st0:4'd2, st1:4'd1, tdc:8'h3C, temp:16'h7E81, autom:1'b0},
        '{d0:12'd1024, d1:12'd0,    st0:4'd1, st1:4'd1, tdc:8'h11, temp:16'h2222, autom:1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, start_acq, auto_rst_en, ext_rst, rd_done, trig_in;
    logic [1:0]  dv_in;
    logic [9:0]  smp0_in, smp1_in;
    logic [7:0]  aux_byte;
    logic        trig_en, buf0_we, buf1_we;
    logic [1:0]  aux_sel, ch_err;
    logic [7:0]  buf0_addr, buf1_addr, status, time_word;
    logic [9:0]  buf0_data, buf1_data;
    logic [15:0] evt_cnt, temp_word;

    logic [7:0]  tdc_val;
    logic [15:0] temp_val;
    logic [9:0]  mem0 [256];
    logic [9:0]  mem1 [256];
    int wr0, wr1;
    int n_chk = 0;
    int n_err = 0;
    bit fin_run = 0;

    always #2.5 clk = ~clk;

    evt_acq_top i_evt_acq_top (
        .clk(clk), .rst_n(rst_n), .start_acq(start_acq), .auto_rst_en(auto_rst_en),
        .ext_rst(ext_rst), .rd_done(rd_done), .trig_in(trig_in), .dv_in(dv_in),
        .smp0_in(smp0_in), .smp1_in(smp1_in), .aux_byte(aux_byte),
        .trig_en(trig_en), .aux_sel(aux_sel),
        .buf0_we(buf0_we), .buf0_addr(buf0_addr), .buf0_data(buf0_data),
        .buf1_we(buf1_we), .buf1_addr(buf1_addr), .buf1_data(buf1_data),
        .status(status), .ch_err(ch_err), .evt_cnt(evt_cnt),
        .time_word(time_word), .temp_word(temp_word)
    );

    assign aux_byte = (aux_sel == 2'd0) ? tdc_val :
                      (aux_sel == 2'd1) ? temp_val[7:0] :
                      (aux_sel == 2'd2) ? temp_val[15:8] : 8'h00;

    always @(negedge clk) begin
        if (buf0_we) begin mem0[buf0_addr] = buf0_data; wr0++; end
        if (buf1_we) begin mem1[buf1_addr] = buf1_data; wr1++; end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_evt(input vec_t v, input int k);
        logic [9:0] f0, f1, e;
        bit ok0, ok1, seen;
        int bad0, bad1;
        ok0 = (v.d0 < 12'd1024);
        ok1 = (v.d1 < 12'd1024);
        f0 = '0; f1 = '0; seen = 0; bad0 = 0; bad1 = 0;
        tdc_val = v.tdc; temp_val = v.temp;
        auto_rst_en = v.autom;
        if (v.autom) rd_done = 1'b1; else ext_rst = 1'b1;
        @(negedge clk);
        rd_done = 1'b0; ext_rst = 1'b0;
        chk(trig_en == 1'b1, "R9", "rearm after reset", trig_en, 1);
        chk(status[7] == 1'b0, "R2", "ready cleared by selected reset", status[7], 0);
        wr0 = 0; wr1 = 0;
        trig_in = 1'b1;
        for (int c = 0; c < 1400; c++) begin
            @(negedge clk);
            if (c == 0) begin
                trig_in = 1'b0;
                chk(trig_en == 1'b0, "R3", "veto after trigger", trig_en, 0);
                chk(status[0] == 1'b1, "R8", "busy bit in capture", status[0], 1);
                chk(status[5:4] == 2'b00, "R10", "done flags cleared", status[5:4], 0);
                chk(evt_cnt == 16'(k + 1), "R3", "count after trigger", evt_cnt, k + 1);
            end
            if (status[7]) begin seen = 1; break; end
            if (c == 2) trig_in = 1'b1;
            if (c == 3) trig_in = 1'b0;
            smp0_in = smp0_in + 10'(v.st0);
            smp1_in = smp1_in + 10'(v.st1);
            if (c == int'(v.d0)) begin dv_in[0] = 1'b1; f0 = smp0_in; end
            if (c == int'(v.d1)) begin dv_in[1] = 1'b1; f1 = smp1_in; end
        end
        dv_in = 2'b00;
        chk(seen, "R7", "event became ready", seen, 1);
        chk(status == {1'b1, 1'b0, ok1, ok0, 4'b0000}, "R8", "status at ready",
            status, {1'b1, 1'b0, ok1, ok0, 4'b0000});
        chk(ch_err == {!ok1, !ok0}, "R6", "timeout flags", ch_err, {!ok1, !ok0});
        chk(evt_cnt == 16'(k + 1), "R3", "count ignores vetoed trigger", evt_cnt, k + 1);
        chk(time_word == v.tdc, "R7", "timing byte", time_word, v.tdc);
        chk(temp_word == v.temp, "R7", "temperature word", temp_word, v.temp);
        chk(wr0 == (ok0 ? 160 : 0), "R5", "channel 0 write count", wr0, ok0 ? 160 : 0);
        chk(wr1 == (ok1 ? 160 : 0), "R5", "channel 1 write count", wr1, ok1 ? 160 : 0);
        for (int i = 0; i < 160; i++) begin
            e = f0 + 10'(i * int'(v.st0));
            if (ok0 && mem0[i] !== e) bad0++;
            e = f1 + 10'(i * int'(v.st1));
            if (ok1 && mem1[i] !== e) bad1++;
        end
        chk(bad0 == 0, "R4", "channel 0 sample order", bad0, 0);
        chk(bad1 == 0, "R4", "channel 1 sample order", bad1, 0);
        if (v.autom) ext_rst = 1'b1; else rd_done = 1'b1;
        trig_in = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0; rd_done = 1'b0; trig_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(status[7] == 1'b1, "R2", "other reset source ignored", status[7], 1);
        chk(trig_en == 1'b0, "R9", "ready keeps veto", trig_en, 0);
        chk(evt_cnt == 16'(k + 1), "R3", "trigger in ready ignored", evt_cnt, k + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin_run) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int hold;
        rst_n = 1'b0; start_acq = 1'b0; auto_rst_en = 1'b0; ext_rst = 1'b0;
        rd_done = 1'b0; trig_in = 1'b0; dv_in = 2'b00;
        smp0_in = 10'h3F0; smp1_in = 10'h015; tdc_val = '0; temp_val = '0;
        repeat (3) @(negedge clk);
        chk(status == 8'h00, "R1", "reset status", status, 0);
        chk(evt_cnt == 16'h0, "R1", "reset counter", evt_cnt, 0);
        chk(trig_en == 1'b0, "R1", "reset trigger disabled", trig_en, 0);
        chk(buf0_we == 1'b0 && buf1_we == 1'b0, "R1", "reset no writes", {buf1_we, buf0_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        start_acq = 1'b1;
        @(negedge clk);
        start_acq = 1'b0;
        trig_in = 1'b1;
        rd_done = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        rd_done = 1'b0;
        @(negedge clk);
        chk(trig_en == 1'b0, "R2", "readout-done ignored in external mode", trig_en, 0);
        chk(evt_cnt == 16'h0, "R3", "trigger before arming ignored", evt_cnt, 0);

        for (int k = 0; k < NV; k++) run_evt(VECS[k], k);

        @(negedge clk);
        start_acq = 1'b1;
        @(negedge clk);
        start_acq = 1'b0;
        chk(evt_cnt == 16'h0, "R1", "command clears counter", evt_cnt, 0);
        chk(status == 8'h00, "R1", "command clears status", status, 0);
        chk(trig_en == 1'b0, "R1", "command disables trigger", trig_en, 0);
        @(negedge clk);
        auto_rst_en = 1'b0;
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
        chk(trig_en == 1'b1, "R1", "armed after reset", trig_en, 1);
        wr0 = 0; wr1 = 0;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        dv_in = 2'b11;
        repeat (20) @(negedge clk);
        start_acq = 1'b1;
        @(negedge clk);
        start_acq = 1'b0;
        dv_in = 2'b00;
        repeat (4) @(negedge clk);
        hold = wr0;
        repeat (10) @(negedge clk);
        chk(wr0 == hold, "R1", "command aborts capture", wr0, hold);
        chk(status == 8'h00, "R1", "status after abort", status, 0);
        chk(evt_cnt == 16'h0, "R1", "counter after abort", evt_cnt, 0);

        fin_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule